// File: doc/BRIEF.md
# Configurable Sum-of-Products Cell

A purely combinational arithmetic cell that adds up a list of terms and a set of single-bit addends. The list is fixed when the cell is elaborated. Each term is either one factor alone, or the product of two factors. The factors for all terms arrive on one packed operand bus. A second bus carries one-bit addends, and each of those adds 0 or 1 to the total. The result is the total, truncated to the result width.

The shape of the term list is given by a single packed configuration parameter, and that parameter describes itself. A 4-bit header, least significant bit first, gives N. N is the width of every size field that follows. After the header comes one record per term, each of 2+2N bits. Starting from the low end, a record holds:

- a flag that marks both factors as signed;
- a flag that turns the term into a subtraction;
- the width of factor A, an N-bit field with its LSB first;
- the width of factor B, an N-bit field with its LSB first.

Elaboration stops with an error in three cases: the configuration length is not 4 plus a whole number of records, the factor widths do not add up to the operand bus width, or a term has a factor A of width zero.

Top module: `smacc_top`

## Requirements
- R1: The N header (configuration bits 3:0, LSB first) sets the size-field width, and each record starts at bit 4 + t·(2+2N) for term t.
- R2: Within a record, bit 0 is the signed flag, bit 1 is the subtract flag, and the next N bits and the N bits after them are the widths of factor A and factor B.
- R3: The operand bus holds factor A and then factor B of term 0, then term 1, and so on, packed from bit 0 with no gaps. A term whose factor A is all zero contributes zero.
- R4: A term whose factor B width is zero contributes factor A by itself, not a product.
- R5: With the signed flag set, both factors are sign-extended to the result width. With it clear, both are zero-extended.
- R6: A term with the subtract flag set is subtracted from the sum, and any other term is added.
- R7: Each bit of the addend bus adds 0 or 1 as an unsigned value. With the operand bus all zero, the result equals the number of set addend bits.
- R8: The result is the exact sum taken modulo 2^RES_W, and higher bits are dropped.
- R9: With both input buses at zero, the result is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | OPND_W | Packed factors of all terms, term 0 at bit 0 |
| bitAddends | input | BIT_W | Independent one-bit unsigned addends |
| result | output | RES_W | Sum of all terms and addends, modulo 2^RES_W |

## Verification
The cell has no registers, so every result is due in the same cycle as the inputs that produce it: zero cycles of latency. The bench changes the inputs on the falling clock edge and samples the result one nanosecond later, well before the next rising edge, so every sample sees settled logic. Three instances with different configurations run side by side: a 3-bit header with mixed signed and unsigned terms, a 4-bit header with a signed subtracted product, and a 2-bit header with a narrow result that forces wrap-around. Each instance is checked against a hand-written reference function over random inputs, and also on directed corner values.

// File: rtl/smacc_pkg.sv
package smacc_pkg;

  // Upper bound on configuration length handled by the decode helpers.
  localparam int CFG_MAX = 1024;
  typedef logic [CFG_MAX-1:0] cfgVec_t;

  // Per-term strobes from the decoder to a term datapath.
  typedef struct packed {
    logic isSigned;
    logic useMul;
  } termCtl_t;

  function automatic int fieldAt(cfgVec_t cfg, int pos, int len);
    int v = 0;
    for (int i = 0; i < len; i++)
      if (cfg[pos+i]) v = v | (1 << i);
    return v;
  endfunction

  function automatic int sizeBits(cfgVec_t cfg);
    return fieldAt(cfg, 0, 4);
  endfunction

  function automatic int recLen(cfgVec_t cfg);
    return 2 + 2 * sizeBits(cfg);
  endfunction

  function automatic int recBase(cfgVec_t cfg, int t);
    return 4 + t * recLen(cfg);
  endfunction

  function automatic int termCount(cfgVec_t cfg, int cfgW);
    return (cfgW < 4) ? 0 : (cfgW - 4) / recLen(cfg);
  endfunction

  function automatic logic signedOf(cfgVec_t cfg, int t);
    return cfg[recBase(cfg, t)];
  endfunction

  function automatic logic subOf(cfgVec_t cfg, int t);
    return cfg[recBase(cfg, t) + 1];
  endfunction

  function automatic int widthA(cfgVec_t cfg, int t);
    return fieldAt(cfg, recBase(cfg, t) + 2, sizeBits(cfg));
  endfunction

  function automatic int widthB(cfgVec_t cfg, int t);
    return fieldAt(cfg, recBase(cfg, t) + 2 + sizeBits(cfg), sizeBits(cfg));
  endfunction

  // Bit position of factor A of term t on the operand bus.
  function automatic int offsetOf(cfgVec_t cfg, int t);
    int off = 0;
    for (int k = 0; k < t; k++) off += widthA(cfg, k) + widthB(cfg, k);
    return off;
  endfunction

  function automatic int packedWidth(cfgVec_t cfg, int nTerms);
    return offsetOf(cfg, nTerms);
  endfunction

endpackage

// File: rtl/smacc_ctrl.sv
module smacc_ctrl
  import smacc_pkg::*;
#(
  parameter int CFG_W = 28,
  parameter logic [CFG_W-1:0] CFG = '0,
  parameter int N_TERMS = 1
) (
  output termCtl_t termCtl [N_TERMS],
  output logic [N_TERMS-1:0] subMask
);
  localparam cfgVec_t CFG_EXT = cfgVec_t'(CFG);

  for (genvar t = 0; t < N_TERMS; t++) begin : gTermCtl
    localparam logic SGN = signedOf(CFG_EXT, t);
    localparam logic SUB = subOf(CFG_EXT, t);
    localparam logic MUL = (widthB(CFG_EXT, t) != 0);
    assign termCtl[t].isSigned = SGN;
    assign termCtl[t].useMul   = MUL;
    assign subMask[t]          = SUB;
  end
endmodule

// File: rtl/smacc_term.sv
module smacc_term
  import smacc_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int WA = 4,
  parameter int WB = 3,
  localparam int WB_P = (WB == 0) ? 1 : WB
) (
  input  logic [WA-1:0]    facA,
  input  logic [WB_P-1:0]  facB,
  input  termCtl_t         ctl,
  output logic [RES_W-1:0] termVal
);
  logic [RES_W-1:0] extA;
  logic [RES_W-1:0] extB;
  logic [RES_W-1:0] prod;

  always_comb begin
    if (ctl.isSigned) begin
      extA = RES_W'($signed(facA));
      extB = RES_W'($signed(facB));
    end else begin
      extA = RES_W'(facA);
      extB = RES_W'(facB);
    end
  end

  // Product of the extended factors is already the true product mod 2^RES_W.
  assign prod    = extA * extB;
  assign termVal = ctl.useMul ? prod : extA;
endmodule

// File: rtl/smacc_accum.sv
module smacc_accum #(
  parameter int RES_W = 10,
  parameter int N_TERMS = 1,
  parameter int BIT_W = 1
) (
  input  logic [RES_W-1:0]   termVal [N_TERMS],
  input  logic [N_TERMS-1:0] subMask,
  input  logic [BIT_W-1:0]   bitAddends,
  output logic [RES_W-1:0]   result
);
  logic [RES_W-1:0] acc;

  always_comb begin
    acc = '0;
    for (int t = 0; t < N_TERMS; t++)
      acc = subMask[t] ? (acc - termVal[t]) : (acc + termVal[t]);
    for (int b = 0; b < BIT_W; b++)
      acc = acc + RES_W'(bitAddends[b]);
  end

  assign result = acc;
endmodule

// File: rtl/smacc_top.sv
module smacc_top
  import smacc_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int OPND_W = 17,
  parameter int BIT_W = 3,
  parameter int CFG_W = 28,
  parameter logic [CFG_W-1:0] CFG = 28'h4C16713
) (
  input  logic [OPND_W-1:0] opnd,
  input  logic [BIT_W-1:0]  bitAddends,
  output logic [RES_W-1:0]  result
);
  localparam cfgVec_t CFG_EXT = cfgVec_t'(CFG);
  localparam int REC_LEN  = recLen(CFG_EXT);
  localparam int N_TERMS  = termCount(CFG_EXT, CFG_W);
  localparam int PACKED_W = packedWidth(CFG_EXT, N_TERMS);

  if (CFG_W < 4 + REC_LEN || ((CFG_W - 4) % REC_LEN) != 0) begin : gBadCfgLen
    $error("smacc_top: configuration length %0d is not 4 plus whole records of %0d", CFG_W, REC_LEN);
  end
  if (PACKED_W != OPND_W) begin : gBadOpndW
    $error("smacc_top: factor widths sum to %0d, operand bus is %0d", PACKED_W, OPND_W);
  end

  termCtl_t         termCtl [N_TERMS];
  logic [N_TERMS-1:0] subMask;
  logic [RES_W-1:0] termVal [N_TERMS];

  smacc_ctrl #(.CFG_W(CFG_W), .CFG(CFG), .N_TERMS(N_TERMS)) uCtrl (
    .termCtl (termCtl),
    .subMask (subMask)
  );

  for (genvar t = 0; t < N_TERMS; t++) begin : gTerm
    localparam int WA  = widthA(CFG_EXT, t);
    localparam int WB  = widthB(CFG_EXT, t);
    localparam int OFF = offsetOf(CFG_EXT, t);
    localparam int WB_P = (WB == 0) ? 1 : WB;
    logic [WB_P-1:0] facB;

    if (WA == 0) begin : gBadWidthA
      $error("smacc_top: term %0d has an empty factor A", t);
    end
    if (WB == 0) begin : gNoB
      assign facB = '0;
    end else begin : gHasB
      assign facB = opnd[OFF+WA +: WB_P];
    end

    smacc_term #(.RES_W(RES_W), .WA(WA), .WB(WB)) uTerm (
      .facA    (opnd[OFF +: WA]),
      .facB    (facB),
      .ctl     (termCtl[t]),
      .termVal (termVal[t])
    );
  end

  smacc_accum #(.RES_W(RES_W), .N_TERMS(N_TERMS), .BIT_W(BIT_W)) uAccum (
    .termVal    (termVal),
    .subMask    (subMask),
    .bitAddends (bitAddends),
    .result     (result)
  );
endmodule

// File: rtl/smacc_chk.sv
module smacc_chk
  import smacc_pkg::*;
#(
  parameter int RES_W = 10,
  parameter int OPND_W = 17,
  parameter int BIT_W = 3,
  parameter int CFG_W = 28,
  parameter logic [CFG_W-1:0] CFG = '0,
  localparam int N_TERMS = termCount(cfgVec_t'(CFG), CFG_W)
) (
  input logic [OPND_W-1:0] opnd,
  input logic [BIT_W-1:0]  bitAddends,
  input logic [RES_W-1:0]  result,
  input logic [RES_W-1:0]  termVal [N_TERMS]
);
  localparam cfgVec_t CFG_EXT = cfgVec_t'(CFG);

  always_comb begin
    if (opnd == '0)
      AST_BIT_ONLY: assert (result == RES_W'($countones(bitAddends)))
        else $error("addends alone give %0d", result); // R7
  end

  for (genvar t = 0; t < N_TERMS; t++) begin : gTermChk
    localparam int WA  = widthA(CFG_EXT, t);
    localparam int WB  = widthB(CFG_EXT, t);
    localparam int OFF = offsetOf(CFG_EXT, t);
    localparam logic SGN = signedOf(CFG_EXT, t);
    localparam int LOW = (WA < RES_W) ? WA : RES_W;

    always_comb begin
      if (opnd[OFF +: WA] == '0)
        AST_ZERO_FACTOR: assert (termVal[t] == '0)
          else $error("term %0d nonzero with zero factor A", t); // R3
    end

    if (WB == 0) begin : gPlain
      always_comb begin
        AST_PLAIN_LOW: assert (termVal[t][LOW-1:0] == opnd[OFF +: LOW])
          else $error("plain term %0d low bits differ", t); // R4
      end
      if (WA < RES_W) begin : gFill
        always_comb begin
          AST_EXT_FILL: assert (termVal[t][RES_W-1:WA] == {(RES_W-WA){SGN && opnd[OFF+WA-1]}})
            else $error("plain term %0d extension wrong", t); // R5
        end
      end
    end
  end
endmodule

bind smacc_top smacc_chk #(
  .RES_W(RES_W), .OPND_W(OPND_W), .BIT_W(BIT_W), .CFG_W(CFG_W), .CFG(CFG)
) uChk (
  .opnd       (opnd),
  .bitAddends (bitAddends),
  .result     (result),
  .termVal    (termVal)
);

// File: tb/smacc_top_test.sv
module smacc_top_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // Config A: N=3; T0 signed add 4x3, T1 unsigned sub 5 alone, T2 unsigned add 3x2
  logic [16:0] opndA; logic [2:0] bitsA; logic [9:0]  resA;
  // Config B: N=4; T0 signed sub 6x5, T1 signed add 7 alone
  logic [17:0] opndB; logic [4:0] bitsB; logic [11:0] resB;
  // Config C: N=2; T0 unsigned add 3x3, T1 signed sub 2x2, 4-bit result
  logic [9:0]  opndC; logic [0:0] bitsC; logic [3:0]  resC;

  smacc_top #(.RES_W(10), .OPND_W(17), .BIT_W(3), .CFG_W(28),
              .CFG({8'h4C, 8'h16, 8'h71, 4'd3})) uut (
    .opnd(opndA), .bitAddends(bitsA), .result(resA));
  smacc_top #(.RES_W(12), .OPND_W(18), .BIT_W(5), .CFG_W(24),
              .CFG({10'd29, 10'd347, 4'd4})) uutB (
    .opnd(opndB), .bitAddends(bitsB), .result(resB));
  smacc_top #(.RES_W(4), .OPND_W(10), .BIT_W(1), .CFG_W(16),
              .CFG({6'd43, 6'd60, 4'd2})) uutC (
    .opnd(opndC), .bitAddends(bitsC), .result(resC));

  function automatic logic [9:0] refA(logic [16:0] o, logic [2:0] b);
    longint s;
    s = longint'($signed(o[3:0])) * longint'($signed(o[6:4]))
      - longint'(o[11:7])
      + longint'(o[14:12]) * longint'(o[16:15])
      + longint'($countones(b));
    return s[9:0];
  endfunction

  function automatic logic [11:0] refB(logic [17:0] o, logic [4:0] b);
    longint s;
    s = -(longint'($signed(o[5:0])) * longint'($signed(o[10:6])))
      + longint'($signed(o[17:11]))
      + longint'($countones(b));
    return s[11:0];
  endfunction

  function automatic logic [3:0] refC(logic [9:0] o, logic [0:0] b);
    longint s;
    s = longint'(o[2:0]) * longint'(o[5:3])
      - longint'($signed(o[7:6])) * longint'($signed(o[9:8]))
      + longint'(b);
    return s[3:0];
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic drive(logic [16:0] oa, logic [2:0] ba, logic [17:0] ob,
                       logic [4:0] bb, logic [9:0] oc, logic [0:0] bc);
    @(negedge clk);
    opndA = oa; bitsA = ba; opndB = ob; bitsB = bb; opndC = oc; bitsC = bc;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000) begin
      errors++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    opndA = '0; bitsA = '0; opndB = '0; bitsB = '0; opndC = '0; bitsC = '0;

    // R9: all-zero inputs
    drive('0, '0, '0, '0, '0, '0);
    check("R9 cfgA", 32'(resA), 0);
    check("R9 cfgB", 32'(resB), 0);
    check("R9 cfgC", 32'(resC), 0);

    // R3: only term 2 of cfgA driven (A at bit 12, B at bit 15): 5*3
    drive((17'd5 << 12) | (17'd3 << 15), '0, '0, '0, '0, '0);
    check("R3 term2 placement", 32'(resA), 15);

    // R4, R6: cfgA term 1 is factor A alone, subtracted: -9 mod 1024
    drive(17'd9 << 7, '0, '0, '0, '0, '0);
    check("R4 plain subtracted term", 32'(resA), 1015);

    // R5: signed -1 * 3 in cfgA, and signed plain -1 in cfgB
    drive(17'hF | (17'd3 << 4), '0, 18'h7F << 11, '0, '0, '0);
    check("R5 signed product", 32'(resA), 1021);
    check("R5 signed plain extension", 32'(resB), 4095);

    // R6: cfgB term 0 is 3 * (-1), subtracted gives +3
    drive('0, '0, 18'd3 | (18'h1F << 6), '0, '0, '0);
    check("R6 subtracted signed product", 32'(resB), 3);

    // R7: addend bus alone
    drive('0, 3'b101, '0, 5'h1F, '0, 1'b1);
    check("R7 cfgA addends", 32'(resA), 2);
    check("R7 cfgB addends", 32'(resB), 5);
    check("R7 cfgC addend", 32'(resC), 1);

    // R8: cfgC 7*7 = 49 wraps to 1 in 4 bits
    drive('0, '0, '0, '0, 10'd7 | (10'd7 << 3), '0);
    check("R8 wrap", 32'(resC), 1);

    // R1, R2: 2-bit header cfgC, term 1 signed sub (-1)*1 gives +1
    drive('0, '0, '0, '0, (10'd3 << 6) | (10'd1 << 8), '0);
    check("R1 narrow header record", 32'(resC), 1);

    // Random sweep against reference models
    for (int i = 0; i < 400; i++) begin
      logic [16:0] oa; logic [2:0] ba; logic [17:0] ob;
      logic [4:0] bb; logic [9:0] oc; logic [0:0] bc;
      oa = 17'($urandom); ba = 3'($urandom);
      ob = 18'($urandom); bb = 5'($urandom);
      oc = 10'($urandom); bc = 1'($urandom);
      drive(oa, ba, ob, bb, oc, bc);
      check("R8 random cfgA", 32'(resA), 32'(refA(oa, ba)));
      check("R2 random cfgB", 32'(resB), 32'(refB(ob, bb)));
      check("R1 random cfgC", 32'(resC), 32'(refC(oc, bc)));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule